// File: doc/BRIEF.md
# Half-Width ALU with Upper-Half Forwarding

This block is the combinational arithmetic and logic unit of a 32-bit register machine whose datapath really computes on only 16 bits. Every operation works on the low 16 bits of its two operands: the primary operand P and the secondary operand S. S is either a register value or a zero-extended 16-bit immediate. The upper 16 bits of the result are copied from P. The one exception is the exchange-halves operation, which rotates half-words between the operands.

The block produces a 32-bit result and four flags: zero, sign, carry and overflow. These flags describe only the 16-bit part of the result. The surrounding core decides whether to latch the flags, and it handles the memory, branch and stop operations itself. For those operation indices the ALU returns the move value so that the core sees a defined result. Carry-in comes from the core's stored carry flag. It is used as a carry by add-with-carry and as a borrow by subtract-with-borrow.

Top module: `alu16_core`

## Requirements
- R1: For every operation index other than 3, result[31:16] equals P[31:16].
- R2: Index 3 (exchange halves) gives result[15:0] = P[31:16] and result[31:16] = S[15:0].
- R3: Index 0 (move) gives result[15:0] = S[15:0]. Indices 1, 2, 10 and 11 (branch, load, store, stop) return the same value as move.
- R4: Index 6 gives the low half P+S modulo 2^16. Index 7 gives P+S+cin modulo 2^16.
- R5: Index 4 gives the low half P−S modulo 2^16. Index 5 gives P−S−cin modulo 2^16, so cin acts as a borrow-in.
- R6: For indices 6 and 7, cf is the unsigned carry out of bit 15. For indices 4 and 5, cf is 1 exactly when a borrow occurs, that is when the unsigned value P < S (+cin for index 5).
- R7: For indices 4 to 7, of is 1 exactly when the 16-bit two's-complement result does not fit, for example 0x7FFF+1 and 0x8000−1.
- R8: Index 8 shifts P[15:0] left and index 9 shifts it logically right, with zeros shifted in. The shift count is S[3:0], so a count of 16 acts as a count of 0.
- R9: Indices 12, 13, 14 and 15 give P AND S, P OR S, P XOR S and P AND NOT S on the low half.
- R10: zf is 1 exactly when result[15:0] is zero. sf equals result[15].
- R11: For every index outside 4 to 7, cf and of are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation index |
| opnd_p | input | 32 | Primary operand P |
| opnd_s | input | 32 | Secondary operand S (register or zero-extended immediate) |
| carry_in | input | 1 | Stored carry flag, used as carry or borrow input |
| result | output | 32 | Operation result |
| zf | output | 1 | Low-half result is zero |
| sf | output | 1 | Bit 15 of the result |
| cf | output | 1 | Carry out (add) or borrow (subtract) |
| of | output | 1 | Signed overflow of the 16-bit arithmetic |

## Verification
The immediate checks inside the RTL assume that the operation index and the operands hold known two-state values whenever they are evaluated. They also assume that a combinational settle has completed, so that each check reads its inputs and the result from the same evaluation. The bench drives every input from a task one nanosecond after a rising edge and samples at the following falling edge. Every operand it applies is a fully known value, and carry-in is driven in both states for every operation index. This includes the indices that must ignore carry-in.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_MOVE   = 4'd0,
    OP_BRANCH = 4'd1,
    OP_LOAD   = 4'd2,
    OP_SWAPH  = 4'd3,
    OP_SUB    = 4'd4,
    OP_SUBB   = 4'd5,
    OP_ADD    = 4'd6,
    OP_ADDC   = 4'd7,
    OP_SHL    = 4'd8,
    OP_SHR    = 4'd9,
    OP_STORE  = 4'd10,
    OP_STOP   = 4'd11,
    OP_AND    = 4'd12,
    OP_OR     = 4'd13,
    OP_XOR    = 4'd14,
    OP_ANDN   = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_ANDN = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          is_sub,
  input  logic          use_cin,
  input  logic          cin,
  output logic [LW-1:0] sum,
  output logic          cf,
  output logic          of
);

  logic [LW-1:0] b_eff;
  logic          c_eff;
  logic [LW:0]   full;
  logic [LW-1:0] below_msb;

  always_comb begin
    b_eff     = is_sub ? ~b : b;
    c_eff     = is_sub ? ~(use_cin & cin) : (use_cin & cin);
    full      = {1'b0, a} + {1'b0, b_eff} + {{LW{1'b0}}, c_eff};
    below_msb = {1'b0, a[LW-2:0]} + {1'b0, b_eff[LW-2:0]} + {{(LW-1){1'b0}}, c_eff};
    sum       = full[LW-1:0];
    cf        = full[LW] ^ is_sub;
    of        = full[LW] ^ below_msb[LW-1];
  end

  always_comb begin
    // R7
    arith_ovf_chk: assert (of == ((a[LW-1] == b_eff[LW-1]) && (sum[LW-1] != a[LW-1])))
      else $error("overflow flag disagrees with operand and result signs");
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int LW = 16,
  parameter int SW = $clog2(LW)
) (
  input  logic [LW-1:0] val,
  input  logic [SW-1:0] amt,
  input  logic          go_right,
  output logic [LW-1:0] shout
);

  logic [LW-1:0] stage [0:SW];

  assign stage[0] = val;

  for (genvar gi = 0; gi < SW; gi++) begin : g_stage
    localparam int STEP = 1 << gi;
    assign stage[gi+1] = !amt[gi] ? stage[gi]
                       : (go_right ? (stage[gi] >> STEP) : (stage[gi] << STEP));
  end

  assign shout = stage[SW];

  always_comb begin
    // R8
    shift_amt_chk: assert (shout == (go_right ? (val >> amt) : (val << amt)))
      else $error("barrel shifter output mismatch");
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic_sel_e    sel,
  output logic [LW-1:0] y
);

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = a & ~b;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W,
  localparam int SHW    = $clog2(LANE_W)
) (
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] opnd_p,
  input  logic [WORD_W-1:0] opnd_s,
  input  logic              carry_in,
  output logic [WORD_W-1:0] result,
  output logic              zf,
  output logic              sf,
  output logic              cf,
  output logic              of
);

  alu_op_e       op_e;
  logic [LANE_W-1:0] p_lo, p_hi, s_lo;
  logic [LANE_W-1:0] add_y, sh_y, lg_y;
  logic [LANE_W-1:0] lo_res, hi_res;
  logic          ar_cf, ar_of, is_arith, ar_sub, ar_cin;
  logic          unused_s_hi;

  assign op_e        = alu_op_e'(op);
  assign p_lo        = opnd_p[LANE_W-1:0];
  assign p_hi        = opnd_p[WORD_W-1:LANE_W];
  assign s_lo        = opnd_s[LANE_W-1:0];
  assign unused_s_hi = ^opnd_s[WORD_W-1:LANE_W];

  // indices 4..7 form the arithmetic group; bit 1 clear means subtract, bit 0 set uses carry
  assign is_arith = (op[3:2] == 2'b01);
  assign ar_sub   = is_arith & ~op[1];
  assign ar_cin   = is_arith & op[0];

  alu16_arith #(.LW(LANE_W)) u_arith (
    .a(p_lo), .b(s_lo), .is_sub(ar_sub), .use_cin(ar_cin), .cin(carry_in),
    .sum(add_y), .cf(ar_cf), .of(ar_of)
  );

  alu16_shift #(.LW(LANE_W), .SW(SHW)) u_shift (
    .val(p_lo), .amt(s_lo[SHW-1:0]), .go_right(op[0]), .shout(sh_y)
  );

  alu16_logic #(.LW(LANE_W)) u_logic (
    .a(p_lo), .b(s_lo), .sel(logic_sel_e'(op[1:0])), .y(lg_y)
  );

  always_comb begin
    hi_res = p_hi;
    unique case (op_e)
      OP_SWAPH: begin
        lo_res = p_hi;
        hi_res = s_lo;
      end
      OP_SUB, OP_SUBB, OP_ADD, OP_ADDC: lo_res = add_y;
      OP_SHL, OP_SHR:                   lo_res = sh_y;
      OP_AND, OP_OR, OP_XOR, OP_ANDN:   lo_res = lg_y;
      default:                          lo_res = s_lo;
    endcase
  end

  always_comb begin
    result = {hi_res, lo_res};
    zf     = (lo_res == '0);
    sf     = lo_res[LANE_W-1];
    cf     = is_arith & ar_cf;
    of     = is_arith & ar_of;
  end

  always_comb begin
    // R1
    upper_pass_chk: assert ((op == 4'd3) || (result[WORD_W-1:LANE_W] == opnd_p[WORD_W-1:LANE_W]))
      else $error("upper half not forwarded from P");
    // R2
    swap_halves_chk: assert ((op != 4'd3) || (result == {opnd_s[LANE_W-1:0], opnd_p[WORD_W-1:LANE_W]}))
      else $error("exchange-halves result wrong");
    // R10
    zero_flag_chk: assert (zf == (result[LANE_W-1:0] == '0))
      else $error("zero flag wrong");
    // R10
    sign_flag_chk: assert (sf == result[LANE_W-1])
      else $error("sign flag wrong");
    // R11
    quiet_flags_chk: assert ((op >= 4'd4 && op <= 4'd7) || (!cf && !of))
      else $error("carry/overflow set by non-arithmetic op");
  end

endmodule

// File: tb/sim_alu16_core.sv
module sim_alu16_core;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] opnd_p, opnd_s;
  logic        carry_in;
  logic [31:0] result;
  logic        zf, sf, cf, of;
  int          n_chk, n_fail;

  alu16_core u0 (
    .op(op), .opnd_p(opnd_p), .opnd_s(opnd_s), .carry_in(carry_in),
    .result(result), .zf(zf), .sf(sf), .cf(cf), .of(of)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  // independent model of the requirements
  task automatic model(input logic [3:0] o, input logic [31:0] p, input logic [31:0] s,
                       input logic c, output logic [35:0] exp);
    logic [15:0] pl, sl, lo, hi;
    logic        ecf, eof;
    int          u, sg;
    pl = p[15:0]; sl = s[15:0]; hi = p[31:16]; ecf = 0; eof = 0; lo = sl;
    case (o)
      4'd3: begin lo = p[31:16]; hi = sl; end
      4'd6, 4'd7: begin
        u   = int'(pl) + int'(sl) + ((o == 4'd7) ? int'(c) : 0);
        sg  = int'($signed(pl)) + int'($signed(sl)) + ((o == 4'd7) ? int'(c) : 0);
        lo  = u[15:0]; ecf = (u > 65535); eof = (sg > 32767) || (sg < -32768);
      end
      4'd4, 4'd5: begin
        u   = int'(pl) - int'(sl) - ((o == 4'd5) ? int'(c) : 0);
        sg  = int'($signed(pl)) - int'($signed(sl)) - ((o == 4'd5) ? int'(c) : 0);
        lo  = u[15:0]; ecf = (u < 0); eof = (sg > 32767) || (sg < -32768);
      end
      4'd8:  lo = pl << sl[3:0];
      4'd9:  lo = pl >> sl[3:0];
      4'd12: lo = pl & sl;
      4'd13: lo = pl | sl;
      4'd14: lo = pl ^ sl;
      4'd15: lo = pl & ~sl;
      default: lo = sl;
    endcase
    exp = {hi, lo, (lo == 16'd0), lo[15], ecf, eof};
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd3: return "R2";
      4'd4, 4'd5: return "R5/R6/R7";
      4'd6, 4'd7: return "R4/R6/R7";
      4'd8, 4'd9: return "R8";
      4'd12, 4'd13, 4'd14, 4'd15: return "R9";
      default: return "R3/R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [31:0] p, input logic [31:0] s,
                     input logic c, input string req);
    logic [35:0] exp, got;
    @(posedge clk);
    #1;
    op = o; opnd_p = p; opnd_s = s; carry_in = c;
    @(negedge clk);
    model(o, p, s, c, exp);
    got = {result, zf, sf, cf, of};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (R1/R10 flags) op=%0d p=%h s=%h c=%0b: got %h exp %h",
               req, o, p, s, c, got, exp);
    end
  endtask

  // reset state: zero inputs produce a zero result with zero flag set (R3, R10)
  task automatic t_reset_state();
    run(4'd0, 32'h0, 32'h0, 1'b0, "R3 R10 reset");
  endtask

  // R7 corner cases
  task automatic t_overflow_edges();
    run(4'd6, 32'hABCD_7FFF, 32'h1, 1'b0, "R7 7FFF+1");
    run(4'd4, 32'h1234_8000, 32'h1, 1'b0, "R7 8000-1");
    run(4'd7, 32'h0000_7FFE, 32'h1, 1'b1, "R4 R7 adc");
  endtask

  // R6 carry and borrow
  task automatic t_carry_borrow();
    run(4'd6, 32'h0000_FFFF, 32'h1, 1'b0, "R6 carry out");
    run(4'd4, 32'h0000_0000, 32'h1, 1'b0, "R6 borrow");
    run(4'd5, 32'h0000_0005, 32'h5, 1'b1, "R5 R6 sbb borrow-in");
    run(4'd5, 32'h0000_0005, 32'h5, 1'b0, "R5 R10 sbb equal");
  endtask

  // R8 shift count wraps: 16 behaves as 0, 15 is the maximum
  task automatic t_shift_edges();
    run(4'd8, 32'h5555_8001, 32'h10, 1'b0, "R8 shl by 16");
    run(4'd9, 32'h5555_8001, 32'h10, 1'b0, "R8 shr by 16");
    run(4'd8, 32'h0000_0001, 32'hF, 1'b0, "R8 shl by 15");
    run(4'd9, 32'h0000_8000, 32'hF, 1'b0, "R8 shr by 15");
  endtask

  // R2 exchange halves, R3 move ignores carry-in, R11 quiet flags
  task automatic t_special();
    run(4'd3, 32'hDEAD_BEEF, 32'h9999_1357, 1'b1, "R2 exchange");
    run(4'd0, 32'hCAFE_0000, 32'h0000_8000, 1'b1, "R1 R3 move");
    run(4'd2, 32'h1111_2222, 32'h3333_4444, 1'b1, "R3 load pass");
    run(4'd12, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, "R11 and flags");
  endtask

  // all indices on random operands
  task automatic t_sweep();
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 40; k++) begin
        logic [31:0] rp, rs;
        rp = $urandom;
        rs = (k % 2 == 0) ? {16'h0, rp[31:16] ^ 16'h5A5A} : $urandom;
        if (k % 5 == 0) rs = {16'h0, $urandom_range(0, 20)};
        run(4'(o), rp, rs, 1'(k % 3 == 0), req_of(4'(o)));
      end
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    op = '0; opnd_p = '0; opnd_s = '0; carry_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_overflow_edges();
    t_carry_borrow();
    t_shift_edges();
    t_special();
    t_sweep();
    summary();
  end

endmodule